// File: doc/BRIEF.md
# SDRAM Command Timing Gate

This block sits between an SDRAM command source and the command pins of the memory. The source raises a request that carries a command code. The gate grants the request in the cycle that every spacing rule allows it, and drives the command onto the pins one cycle later. While a request is held, the pins carry NOP. The spacing rules are the minimum gap from activate to a column access, from a column access to precharge, from precharge to any command, from refresh to the next refresh, and a fixed gap from refresh to any non-refresh command.

A 16-bit configuration word programs every gap as a 2-bit code. It also sets the CAS latency and the column count. The block decodes the column count into a column address width, so that the surrounding logic can split an address into row and column. The block flags the cycle in which read data is due, which is the programmed CAS latency after each read leaves on the pins.

A gap is counted as the difference in cycle index between two commands seen on `sd_cmd`. A requirement that gives a gap of N cycles means the second command appears no earlier than N cycles after the first, and appears exactly then if it was requested early and held.

Top module: `sdram_cmd_gate`

## Requirements
- R1: The configuration word resets to 0x0130. A write stores bits 10:0 and the readback shows them in the next cycle. Bits 15:11 always read as zero, whatever was written to them.
- R2: `col_bits` gives the column address width from bits 1:0: 00 gives 8 (256 columns), 01 gives 9, 10 gives 10, and the reserved code 11 gives 10.
- R3: Bit 2 selects the CAS latency, 0 for 2 cycles and 1 for 3 cycles. `rd_valid` is high for one cycle, exactly that many cycles after a read (code 2) appears on `sd_cmd`, and is low at every other cycle.
- R4: Bits 4:3 set the gap from activate (code 1) to read or write (codes 2, 3): 10 gives 2, 11 gives 3, 00 gives 4, and the reserved code 01 gives 4.
- R5: Bits 6:5 set the gap from read or write to precharge (code 4): 01 gives 1, 10 gives 2, 11 gives 3, 00 gives 4.
- R6: Bits 8:7 set the gap from precharge to any of activate, read, write, precharge or refresh, using the same mapping as R5.
- R7: Bits 10:9 set the gap from refresh (code 5) to the next refresh: 10 gives 3, 11 gives 7, 00 gives 15, and the reserved code 01 gives 15.
- R8: After a refresh, activate, read, write and precharge wait at least 15 cycles, whatever bits 10:9 hold.
- R9: `req_grant` rises in the same cycle as `req_valid` when no rule blocks the request. A granted command appears on `sd_cmd` in the next cycle. A blocked request is granted in the first cycle its gap has elapsed, and `sd_cmd` carries NOP (code 0) while it waits.
- R10: A request with code 0, 6 or 7 is granted at once, even while gaps are running. It drives NOP and leaves all gap timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| req_valid | input | 1 | Command request from the source |
| req_cmd | input | 3 | Requested command code |
| req_grant | output | 1 | Request accepted this cycle |
| sd_cmd | output | 3 | Command code driven to the memory pins |
| rd_valid | output | 1 | Read data due this cycle |
| col_bits | output | 4 | Column address width in bits |

## Verification
A granted command reaches `sd_cmd` one clock edge after the grant cycle. Its gap timers run from that same edge, so the bench stamps the cycle index at the falling edge after each grant and checks the difference between two stamps against the programmed gap. Configuration writes take effect one edge after the write strobe, and the bench reads `cfg_rdata` and `col_bits` at the next falling edge. `rd_valid` is checked at each of the four falling edges that follow a read on the pins, and must be high only at the edge whose offset equals the CAS latency.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;

    localparam int CFG_W    = 16;
    localparam int CMD_W    = 3;
    localparam int GAP_W    = 4;
    localparam int NUM_GAPS = 5;
    localparam int NUM_CMDS = 1 << CMD_W;

    // Gap classes, one timer each
    localparam int G_ARW = 0;   // activate -> column access
    localparam int G_RWP = 1;   // column access -> precharge
    localparam int G_PRE = 2;   // precharge -> anything
    localparam int G_RR  = 3;   // refresh -> refresh
    localparam int G_RO  = 4;   // refresh -> other

    localparam int REF_OTHER_CYC = 15;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h0130;
    localparam logic [CFG_W-1:0] LIVE_MASK = 16'h07FF;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } sd_cmd_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic [1:0] rr_code;
        logic [1:0] pre_code;
        logic [1:0] rwp_code;
        logic [1:0] arw_code;
        logic       cas3;
        logic [1:0] col_code;
    } cfg_t;

    // Per gap class: which command codes start it, which it holds off (bit = code)
    localparam logic [NUM_GAPS-1:0][NUM_CMDS-1:0] START_M =
        {8'h20, 8'h20, 8'h10, 8'h0C, 8'h02};
    localparam logic [NUM_GAPS-1:0][NUM_CMDS-1:0] BLOCK_M =
        {8'h1E, 8'h20, 8'h3E, 8'h10, 8'h0C};

    function automatic logic [GAP_W-1:0] arw_cycles(input logic [1:0] code);
        case (code)
            2'b10:   return GAP_W'(2);
            2'b11:   return GAP_W'(3);
            default: return GAP_W'(4);   // 00, and reserved 01 falls back to the longest
        endcase
    endfunction

    function automatic logic [GAP_W-1:0] std_cycles(input logic [1:0] code);
        return (code == 2'b00) ? GAP_W'(4) : GAP_W'(code);
    endfunction

    function automatic logic [GAP_W-1:0] rr_cycles(input logic [1:0] code);
        case (code)
            2'b10:   return GAP_W'(3);
            2'b11:   return GAP_W'(7);
            default: return GAP_W'(15);  // 00, and reserved 01 falls back to the longest
        endcase
    endfunction

    function automatic logic [3:0] col_width(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd8;
            2'b01:   return 4'd9;
            default: return 4'd10;
        endcase
    endfunction

    function automatic logic [GAP_W-1:0] gap_of(input int g, input cfg_t c);
        case (g)
            G_ARW:   return arw_cycles(c.arw_code);
            G_RWP:   return std_cycles(c.rwp_code);
            G_PRE:   return std_cycles(c.pre_code);
            G_RR:    return rr_cycles(c.rr_code);
            default: return GAP_W'(REF_OTHER_CYC);
        endcase
    endfunction

    function automatic logic is_mem_cmd(input logic [CMD_W-1:0] c);
        return (c >= CMD_ACT) && (c <= CMD_REF);
    endfunction

endpackage

// File: rtl/sdram_gate_cfg.sv
module sdram_gate_cfg
    import sdram_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= cfg_t'(CFG_RESET);
        else if (we) cfg_q <= cfg_t'(wdata & LIVE_MASK);
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_q;

    assert_write_readback_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata == ($past(wdata) & LIVE_MASK)));

endmodule

// File: rtl/sdram_gate_timer.sv
module sdram_gate_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)                 count_q <= '0;
        else if (load)           count_q <= load_val;
        else if (count_q != '0)  count_q <= count_q - 1'b1;
    end

    assign busy = (count_q != '0);

    assert_count_down_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && busy) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/sdram_gate_rdv.sv
module sdram_gate_rdv #(
    parameter int MAX_LAT = 3,
    localparam int LW = $clog2(MAX_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_issue,
    input  logic [LW-1:0] lat,
    output logic          rd_valid
);

    logic [MAX_LAT:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[MAX_LAT-1:0], rd_issue};
    end

    assign rd_valid = pipe_q[lat];

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
    import sdram_gate_pkg::*;
#(
    parameter int SINCE_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             req_valid,
    input  logic [CMD_W-1:0] req_cmd,
    output logic             req_grant,
    output logic [CMD_W-1:0] sd_cmd,
    output logic             rd_valid,
    output logic [3:0]       col_bits
);

    localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

    cfg_t cfg;

    sdram_gate_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    logic [NUM_GAPS-1:0][GAP_W-1:0] gap_val;
    logic [NUM_GAPS-1:0]            busy;
    logic [NUM_GAPS-1:0]            load;
    logic [NUM_GAPS-1:0]            hit;
    logic [CMD_W-1:0]               sd_cmd_q;

    for (genvar g = 0; g < NUM_GAPS; g++) begin : gen_gap
        assign gap_val[g] = gap_of(g, cfg);
        assign load[g]    = req_grant && START_M[g][req_cmd];
        assign hit[g]     = busy[g] && BLOCK_M[g][req_cmd];

        sdram_gate_timer #(.W(GAP_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .load     (load[g]),
            .load_val (gap_val[g] - GAP_W'(1)),
            .busy     (busy[g])
        );

        // Independent observer: cycles since the starting command left on the pins
        logic [SINCE_W-1:0] since_q;
        logic [GAP_W-1:0]   pend_q;
        logic [GAP_W-1:0]   need_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                since_q <= SINCE_MAX;
                pend_q  <= GAP_W'(REF_OTHER_CYC);
                need_q  <= GAP_W'(REF_OTHER_CYC);
            end else begin
                if (load[g]) pend_q <= gap_val[g];
                if (START_M[g][sd_cmd_q]) begin
                    since_q <= SINCE_W'(1);
                    need_q  <= pend_q;
                end else if (since_q != SINCE_MAX) begin
                    since_q <= since_q + 1'b1;
                end
            end
        end

        assert_min_gap_R4_R5_R6_R7_R8: assert property (@(posedge clk) disable iff (rst)
            BLOCK_M[g][sd_cmd_q] |-> (since_q >= SINCE_W'(need_q)));
    end

    assign req_grant = req_valid && !(|hit);

    always_ff @(posedge clk) begin
        if (rst)                                   sd_cmd_q <= CMD_NOP;
        else if (req_grant && is_mem_cmd(req_cmd)) sd_cmd_q <= req_cmd;
        else                                       sd_cmd_q <= CMD_NOP;
    end

    assign sd_cmd = sd_cmd_q;

    sdram_gate_rdv #(.MAX_LAT(3)) u_rdv (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (req_grant && (req_cmd == CMD_RD)),
        .lat      (cfg.cas3 ? 2'd3 : 2'd2),
        .rd_valid (rd_valid)
    );

    assign col_bits = col_width(cfg.col_code);

    assert_rdv_cl2_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !cfg.cas3) |-> ($past(sd_cmd_q, 2) == CMD_RD));

    assert_rdv_cl3_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && cfg.cas3) |-> ($past(sd_cmd_q, 3) == CMD_RD));

    assert_filler_nop_R10: assert property (@(posedge clk) disable iff (rst)
        (req_grant && !is_mem_cmd(req_cmd)) |=> (sd_cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_cmd_gate_bench.sv
module sdram_cmd_gate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic        req_grant;
    logic [2:0]  sd_cmd;
    logic        rd_valid;
    logic [3:0]  col_bits;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_gate u_sdram_cmd_gate (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_valid (req_valid),
        .req_cmd   (req_cmd),
        .req_grant (req_grant),
        .sd_cmd    (sd_cmd),
        .rd_valid  (rd_valid),
        .col_bits  (col_bits)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] col, input logic cl,
                                       input logic [1:0] arw, input logic [1:0] rwp,
                                       input logic [1:0] pre, input logic [1:0] rr);
        return {5'b0, rr, pre, rwp, arw, cl, col};
    endfunction

    function automatic int e_arw(input logic [1:0] c);
        return (c == 2'b10) ? 2 : (c == 2'b11) ? 3 : 4;
    endfunction
    function automatic int e_std(input logic [1:0] c);
        return (c == 2'b00) ? 4 : int'(c);
    endfunction
    function automatic int e_rr(input logic [1:0] c);
        return (c == 2'b10) ? 3 : (c == 2'b11) ? 7 : 15;
    endfunction

    task automatic wr_cfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; returns the cycle index at which the command is on the pins
    task automatic send(input logic [2:0] c, output int t, output int nop_ok);
        req_valid = 1'b1; req_cmd = c; nop_ok = 1;
        #1;
        while (!req_grant) begin
            @(negedge clk); #1;
            if (sd_cmd != 3'd0) nop_ok = 0;
        end
        @(posedge clk); @(negedge clk);
        t = cyc;
        req_valid = 1'b0;
        if (c >= 3'd1 && c <= 3'd5) chk("R9 command on pins", int'(sd_cmd), int'(c));
    endtask

    task automatic measure(input string req, input logic [2:0] a, input logic [2:0] b,
                           input int exp);
        int ta, tb, ok;
        idle(20);
        send(a, ta, ok);
        send(b, tb, ok);
        chk(req, tb - ta, exp);
        chk({req, " NOP while held (R9)"}, ok, 1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ta, tb, ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R1 reset value", int'(cfg_rdata), 16'h0130);
        chk("R9 reset pins NOP", int'(sd_cmd), 0);
        chk("R3 reset rd_valid", int'(rd_valid), 0);
        chk("R2 reset col_bits", int'(col_bits), 8);

        // R1 reserved bits
        wr_cfg(16'hFFFF);
        chk("R1 reserved read zero", int'(cfg_rdata), 16'h07FF);
        wr_cfg(16'h0130);
        chk("R1 rewrite", int'(cfg_rdata), 16'h0130);

        // R2 column width sweep
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(2'(c), 1'b0, 2'b10, 2'b01, 2'b10, 2'b00));
            chk("R2 col_bits", int'(col_bits), (c == 0) ? 8 : (c == 1) ? 9 : 10);
        end

        // R4 activate to column access
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(2'b00, 1'b0, 2'(c), 2'b01, 2'b10, 2'b00));
            measure("R4 ACT->RD", 3'd1, 3'd2, e_arw(2'(c)));
            measure("R4 ACT->WR", 3'd1, 3'd3, e_arw(2'(c)));
        end

        // R5 column access to precharge
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(2'b00, 1'b0, 2'b10, 2'(c), 2'b10, 2'b00));
            measure("R5 RD->PRE", 3'd2, 3'd4, e_std(2'(c)));
            measure("R5 WR->PRE", 3'd3, 3'd4, e_std(2'(c)));
        end

        // R6 precharge to next command
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(2'b00, 1'b0, 2'b10, 2'b01, 2'(c), 2'b00));
            measure("R6 PRE->ACT", 3'd4, 3'd1, e_std(2'(c)));
            measure("R6 PRE->REF", 3'd4, 3'd5, e_std(2'(c)));
        end

        // R7 refresh to refresh, R8 refresh to other
        for (int c = 0; c < 4; c++) begin
            wr_cfg(mk(2'b00, 1'b0, 2'b10, 2'b01, 2'b10, 2'(c)));
            measure("R7 REF->REF", 3'd5, 3'd5, e_rr(2'(c)));
            measure("R8 REF->ACT", 3'd5, 3'd1, 15);
        end
        wr_cfg(mk(2'b00, 1'b0, 2'b10, 2'b01, 2'b10, 2'b10));
        measure("R8 REF->PRE", 3'd5, 3'd4, 15);

        // R3 CAS latency
        for (int cl = 0; cl < 2; cl++) begin
            wr_cfg(mk(2'b00, 1'(cl), 2'b10, 2'b01, 2'b10, 2'b00));
            idle(20);
            send(3'd2, ta, ok);
            chk("R3 rd_valid at read", int'(rd_valid), 0);
            for (int k = 1; k <= 4; k++) begin
                @(negedge clk);
                chk("R3 rd_valid offset", int'(rd_valid), (k == cl + 2) ? 1 : 0);
            end
        end

        // R9 immediate grant when nothing blocks
        idle(20);
        req_valid = 1'b1; req_cmd = 3'd1; #1;
        chk("R9 same-cycle grant", int'(req_grant), 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ACT on pins", int'(sd_cmd), 1);

        // R10 filler codes granted at once and harmless
        idle(20);
        send(3'd5, ta, ok);
        for (int f = 0; f < 3; f++) begin
            req_valid = 1'b1; req_cmd = (f == 0) ? 3'd0 : 3'(f + 5); #1;
            chk("R10 filler grant", int'(req_grant), 1);
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            chk("R10 filler drives NOP", int'(sd_cmd), 0);
        end
        send(3'd1, tb, ok);
        chk("R10 REF->ACT unchanged", tb - ta, 15);

        idle(5);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule